// File: doc/BRIEF.md
# Programmable LCD Scan Timing Generator

This block drives the timing of a progressive-scan TFT panel that has no timing controller of its own. It runs on the pixel clock and keeps a column counter and a row counter. From them it produces a horizontal sync pulse at the start of every line and a vertical sync pulse at the start of every frame. It also produces a data-enable window, which the pixel data path uses to gate its bus onto the panel. The raw column and row position and a one-cycle start-of-frame strobe are output as well.

Each panel differs, so every timing quantity comes from a configuration input:

- line and frame lengths;
- sync widths and sync polarities;
- active pixel and line counts;
- the number of dead pixel clocks, counted from the leading edge of the line sync, before the first displayed pixel;
- the matching number of dead lines, counted from the start of the frame.

The block copies the configuration into shadow registers in two cases: on the first cycle after reset, and at every frame boundary. Configuration changes can therefore be made at any time without tearing a frame. All outputs are registered, so they trail the internal counters by one clock.

A typical small-panel setup is 320 by 240 active pixels at a pixel clock of a few MHz. Any geometry that fits the counter widths is accepted.

Top module: `lcd_scan_timer`

## Requirements
- R1: While rst_n is low, every output is 0, whatever the configuration inputs are. After rst_n rises, the first rising edge leaves every output at 0. The second rising edge raises sof_o, with col_o = 0 and row_o = 0.
- R2: The block samples the configuration inputs on the first rising edge after reset and on the rising edge that ends each frame. A change made during a frame has no effect until the next frame begins.
- R3: col_o counts 0, 1, … up to cfg_h_total − 1. It then returns to 0.
- R4: row_o advances by one each time col_o returns to 0. After cfg_v_total − 1 it returns to 0.
- R5: hsync_o is at its active level while col_o < cfg_h_sync_len, and at the inactive level otherwise.
  - cfg_h_pol = 1 selects active-high; cfg_h_pol = 0 selects active-low.
  - A width of 0 keeps the line sync inactive.
- R6: vsync_o is at its active level while row_o < cfg_v_sync_len, and at the inactive level otherwise. cfg_v_pol selects the polarity with the same encoding as R5. vsync_o changes only in a cycle where col_o = 0, which is the leading edge of the line sync.
- R7: de_o is 1 exactly when both of these hold:
  - cfg_h_dead ≤ col_o < cfg_h_dead + cfg_h_active;
  - cfg_v_dead ≤ row_o < cfg_v_dead + cfg_v_active.

  Any part of a window that extends past the line or frame length is never reached.
- R8: sof_o is 1 for exactly one cycle per frame, the cycle in which col_o = 0 and row_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_total | input | H_W | Line length in pixel clocks |
| cfg_h_sync_len | input | H_W | Line sync width in pixel clocks |
| cfg_h_dead | input | H_W | Dead clocks from line sync start to first active pixel |
| cfg_h_active | input | H_W | Active pixels per line |
| cfg_h_pol | input | 1 | Line sync polarity, 1 = active-high |
| cfg_v_total | input | V_W | Frame length in lines |
| cfg_v_sync_len | input | V_W | Frame sync width in lines |
| cfg_v_dead | input | V_W | Dead lines from frame start to first active line |
| cfg_v_active | input | V_W | Active lines per frame |
| cfg_v_pol | input | 1 | Frame sync polarity, 1 = active-high |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable window |
| col_o | output | H_W | Current column |
| row_o | output | V_W | Current row |
| sof_o | output | 1 | Start-of-frame strobe |

## Verification
The bench steps through every pixel position of whole frames under three geometries:

- The first has active-high syncs and the active window inside the line. It shows that the dead-clock offset and the vertical dead lines are applied.
- The second has active-low syncs and a window that fills the whole line and frame with no dead region. It separates polarity handling and the full-width corner from the offset logic.
- The third has a zero-width line sync, mixed polarities and windows that overrun the line and frame lengths. It separates range clipping and the zero-width case.

Configuration changes are made in the middle of a frame. This shows whether the running frame keeps its old geometry and whether the new geometry starts exactly at the next frame.

// File: rtl/lst_pkg.sv
package lst_pkg;

  localparam int unsigned LST_H_W = 12;
  localparam int unsigned LST_V_W = 11;

  typedef enum logic {
    SYNC_ACT_LOW  = 1'b0,
    SYNC_ACT_HIGH = 1'b1
  } sync_pol_e;

  // Map an internal active flag to the pin level for a given polarity.
  function automatic logic drive_level(input logic active, input sync_pol_e pol);
    return (pol == SYNC_ACT_HIGH) ? active : ~active;
  endfunction

endpackage

// File: rtl/lst_cfg_latch.sv
module lst_cfg_latch #(
  parameter int unsigned H_W = lst_pkg::LST_H_W,
  parameter int unsigned V_W = lst_pkg::LST_V_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [H_W-1:0] h_total,
  input  logic [H_W-1:0] h_sync_len,
  input  logic [H_W-1:0] h_dead,
  input  logic [H_W-1:0] h_active,
  input  logic           h_pol,
  input  logic [V_W-1:0] v_total,
  input  logic [V_W-1:0] v_sync_len,
  input  logic [V_W-1:0] v_dead,
  input  logic [V_W-1:0] v_active,
  input  logic           v_pol,
  output logic [H_W-1:0] sh_h_total,
  output logic [H_W-1:0] sh_h_sync_len,
  output logic [H_W-1:0] sh_h_dead,
  output logic [H_W-1:0] sh_h_active,
  output logic           sh_h_pol,
  output logic [V_W-1:0] sh_v_total,
  output logic [V_W-1:0] sh_v_sync_len,
  output logic [V_W-1:0] sh_v_dead,
  output logic [V_W-1:0] sh_v_active,
  output logic           sh_v_pol
);

  // Shadow copy of the panel geometry; only refreshed on a frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_h_total    <= '0;
      sh_h_sync_len <= '0;
      sh_h_dead     <= '0;
      sh_h_active   <= '0;
      sh_h_pol      <= 1'b0;
      sh_v_total    <= '0;
      sh_v_sync_len <= '0;
      sh_v_dead     <= '0;
      sh_v_active   <= '0;
      sh_v_pol      <= 1'b0;
    end else if (load) begin
      sh_h_total    <= h_total;
      sh_h_sync_len <= h_sync_len;
      sh_h_dead     <= h_dead;
      sh_h_active   <= h_active;
      sh_h_pol      <= h_pol;
      sh_v_total    <= v_total;
      sh_v_sync_len <= v_sync_len;
      sh_v_dead     <= v_dead;
      sh_v_active   <= v_active;
      sh_v_pol      <= v_pol;
    end
  end

endmodule

// File: rtl/lst_axis_counter.sv
module lst_axis_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         at_last
);

  logic [W-1:0] last_pos;
  logic [W-1:0] cnt_d;

  assign last_pos = total - 1'b1;
  assign at_last  = (cnt == last_pos);

  // Next-state: wrap at the programmed length, otherwise step by one.
  always_comb begin
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/lst_axis_window.sv
module lst_axis_window #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] sync_len,
  input  logic [W-1:0] win_start,
  input  logic [W-1:0] win_len,
  output logic         sync_act,
  output logic         in_win
);

  // One extra bit so that start + length never wraps.
  logic [W:0] win_end;

  assign win_end  = {1'b0, win_start} + {1'b0, win_len};
  assign sync_act = (pos < sync_len);
  assign in_win   = (pos >= win_start) && ({1'b0, pos} < win_end);

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int unsigned H_W = lst_pkg::LST_H_W,
  parameter int unsigned V_W = lst_pkg::LST_V_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] cfg_h_total,
  input  logic [H_W-1:0] cfg_h_sync_len,
  input  logic [H_W-1:0] cfg_h_dead,
  input  logic [H_W-1:0] cfg_h_active,
  input  logic           cfg_h_pol,
  input  logic [V_W-1:0] cfg_v_total,
  input  logic [V_W-1:0] cfg_v_sync_len,
  input  logic [V_W-1:0] cfg_v_dead,
  input  logic [V_W-1:0] cfg_v_active,
  input  logic           cfg_v_pol,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [H_W-1:0] col_o,
  output logic [V_W-1:0] row_o,
  output logic           sof_o
);

  import lst_pkg::*;

  // Run flag: low only until the first edge after reset.
  logic started_q;
  logic started_d;

  // Shadow configuration.
  logic [H_W-1:0] sh_h_total, sh_h_sync_len, sh_h_dead, sh_h_active;
  logic [V_W-1:0] sh_v_total, sh_v_sync_len, sh_v_dead, sh_v_active;
  logic           sh_h_pol, sh_v_pol;

  // Counters.
  logic [H_W-1:0] hc;
  logic [V_W-1:0] vc;
  logic           h_at_last, v_at_last;
  logic           frame_end;
  logic           cfg_load;
  logic           h_adv, v_adv;

  // Decode.
  logic h_sync_act, h_in_win, v_sync_act, v_in_win;

  // Output next-state.
  logic           hsync_d, vsync_d, de_d, sof_d;
  logic [H_W-1:0] col_d;
  logic [V_W-1:0] row_d;

  assign started_d = 1'b1;
  assign frame_end = h_at_last & v_at_last;
  assign cfg_load  = ~started_q | frame_end;
  assign h_adv     = started_q;
  assign v_adv     = started_q & h_at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
    end else begin
      started_q <= started_d;
    end
  end

  lst_cfg_latch #(.H_W(H_W), .V_W(V_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cfg_load),
    .h_total      (cfg_h_total),
    .h_sync_len   (cfg_h_sync_len),
    .h_dead       (cfg_h_dead),
    .h_active     (cfg_h_active),
    .h_pol        (cfg_h_pol),
    .v_total      (cfg_v_total),
    .v_sync_len   (cfg_v_sync_len),
    .v_dead       (cfg_v_dead),
    .v_active     (cfg_v_active),
    .v_pol        (cfg_v_pol),
    .sh_h_total   (sh_h_total),
    .sh_h_sync_len(sh_h_sync_len),
    .sh_h_dead    (sh_h_dead),
    .sh_h_active  (sh_h_active),
    .sh_h_pol     (sh_h_pol),
    .sh_v_total   (sh_v_total),
    .sh_v_sync_len(sh_v_sync_len),
    .sh_v_dead    (sh_v_dead),
    .sh_v_active  (sh_v_active),
    .sh_v_pol     (sh_v_pol)
  );

  lst_axis_counter #(.W(H_W)) u_hcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (h_adv),
    .total  (sh_h_total),
    .cnt    (hc),
    .at_last(h_at_last)
  );

  lst_axis_counter #(.W(V_W)) u_vcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (v_adv),
    .total  (sh_v_total),
    .cnt    (vc),
    .at_last(v_at_last)
  );

  lst_axis_window #(.W(H_W)) u_hwin (
    .pos      (hc),
    .sync_len (sh_h_sync_len),
    .win_start(sh_h_dead),
    .win_len  (sh_h_active),
    .sync_act (h_sync_act),
    .in_win   (h_in_win)
  );

  lst_axis_window #(.W(V_W)) u_vwin (
    .pos      (vc),
    .sync_len (sh_v_sync_len),
    .win_start(sh_v_dead),
    .win_len  (sh_v_active),
    .sync_act (v_sync_act),
    .in_win   (v_in_win)
  );

  // Output next-state: held at zero until the counters are running.
  always_comb begin
    if (started_q) begin
      hsync_d = drive_level(h_sync_act, sync_pol_e'(sh_h_pol));
      vsync_d = drive_level(v_sync_act, sync_pol_e'(sh_v_pol));
      de_d    = h_in_win & v_in_win;
      sof_d   = (hc == '0) && (vc == '0);
      col_d   = hc;
      row_d   = vc;
    end else begin
      hsync_d = 1'b0;
      vsync_d = 1'b0;
      de_d    = 1'b0;
      sof_d   = 1'b0;
      col_d   = '0;
      row_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      sof_o   <= 1'b0;
      col_o   <= '0;
      row_o   <= '0;
    end else begin
      hsync_o <= hsync_d;
      vsync_o <= vsync_d;
      de_o    <= de_d;
      sof_o   <= sof_d;
      col_o   <= col_d;
      row_o   <= row_d;
    end
  end

endmodule

// File: rtl/lst_chk.sv
module lst_chk #(
  parameter int unsigned H_W = lst_pkg::LST_H_W,
  parameter int unsigned V_W = lst_pkg::LST_V_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [H_W-1:0] hc,
  input logic [V_W-1:0] vc,
  input logic           h_last,
  input logic           v_last,
  input logic [H_W-1:0] sh_h_dead,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           de_o,
  input logic [H_W-1:0] col_o,
  input logic [V_W-1:0] row_o,
  input logic           sof_o
);

  // Dead-clock setting delayed so that it lines up with the registered outputs.
  logic [H_W-1:0] dead_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q <= '0;
    end else begin
      dead_q <= sh_h_dead;
    end
  end

  a_r3_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_last) |=> (hc == ($past(hc) + 1'b1)));

  a_r3_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_last) |=> (hc == '0));

  a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_last) |=> $stable(vc));

  a_r4_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_last && v_last) |=> (vc == '0));

  a_r6_vsync_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_o) |-> (col_o == '0));

  a_r7_de_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> (col_o == dead_q));

  a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> !sof_o);

  a_r8_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> ((col_o == '0) && (row_o == '0)));

  // hsync_o takes part in the R5 checks in the bench only.
  logic unused_hs;
  assign unused_hs = hsync_o;

endmodule

bind lcd_scan_timer lst_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (started_q),
  .hc       (hc),
  .vc       (vc),
  .h_last   (h_at_last),
  .v_last   (v_at_last),
  .sh_h_dead(sh_h_dead),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .de_o     (de_o),
  .col_o    (col_o),
  .row_o    (row_o),
  .sof_o    (sof_o)
);

// File: tb/lcd_scan_timer_tb_top.sv
module lcd_scan_timer_tb_top;

  localparam int unsigned H_W = 12;
  localparam int unsigned V_W = 11;

  typedef struct {
    int ht, hs, hd, ha, hp;
    int vt, vs, vd, va, vp;
  } geo_t;

  logic           clk;
  logic           rst_n;
  logic [H_W-1:0] cfg_h_total, cfg_h_sync_len, cfg_h_dead, cfg_h_active;
  logic [V_W-1:0] cfg_v_total, cfg_v_sync_len, cfg_v_dead, cfg_v_active;
  logic           cfg_h_pol, cfg_v_pol;
  logic           hsync_o, vsync_o, de_o, sof_o;
  logic [H_W-1:0] col_o;
  logic [V_W-1:0] row_o;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  lcd_scan_timer #(.H_W(H_W), .V_W(V_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_h_total   (cfg_h_total),
    .cfg_h_sync_len(cfg_h_sync_len),
    .cfg_h_dead    (cfg_h_dead),
    .cfg_h_active  (cfg_h_active),
    .cfg_h_pol     (cfg_h_pol),
    .cfg_v_total   (cfg_v_total),
    .cfg_v_sync_len(cfg_v_sync_len),
    .cfg_v_dead    (cfg_v_dead),
    .cfg_v_active  (cfg_v_active),
    .cfg_v_pol     (cfg_v_pol),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .de_o          (de_o),
    .col_o         (col_o),
    .row_o         (row_o),
    .sof_o         (sof_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input geo_t g);
    cfg_h_total    = H_W'(g.ht);
    cfg_h_sync_len = H_W'(g.hs);
    cfg_h_dead     = H_W'(g.hd);
    cfg_h_active   = H_W'(g.ha);
    cfg_h_pol      = g.hp[0];
    cfg_v_total    = V_W'(g.vt);
    cfg_v_sync_len = V_W'(g.vs);
    cfg_v_dead     = V_W'(g.vd);
    cfg_v_active   = V_W'(g.va);
    cfg_v_pol      = g.vp[0];
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  // Check one pixel position of a frame laid out by g.
  task automatic check_pos(input geo_t g, input int c, input int r, input string note);
    int exp_hs, exp_vs, exp_de, exp_sof;
    exp_hs  = (c < g.hs) ? g.hp : 1 - g.hp;
    exp_vs  = (r < g.vs) ? g.vp : 1 - g.vp;
    exp_de  = (c >= g.hd && c < g.hd + g.ha && r >= g.vd && r < g.vd + g.va) ? 1 : 0;
    exp_sof = (c == 0 && r == 0) ? 1 : 0;
    chk({"R3", note}, "col_o",   int'(col_o),   c);
    chk({"R4", note}, "row_o",   int'(row_o),   r);
    chk({"R5", note}, "hsync_o", int'(hsync_o), exp_hs);
    chk({"R6", note}, "vsync_o", int'(vsync_o), exp_vs);
    chk({"R7", note}, "de_o",    int'(de_o),    exp_de);
    chk({"R8", note}, "sof_o",   int'(sof_o),   exp_sof);
  endtask

  // Walk a whole frame; optionally switch the configuration at position chg_at.
  task automatic run_frame(input geo_t g, input int chg_at, input geo_t nxt, input string note);
    for (int p = 0; p < g.ht * g.vt; p++) begin
      check_pos(g, p % g.ht, p / g.ht, note);
      if (p == chg_at) apply(nxt);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual 0 expected 1");
      report();
      $finish;
    end
  end

  initial begin
    geo_t ga, gb, gc;
    // ga: active-high, window inside the line, dead clocks and dead lines.
    ga = '{ht:12, hs:2, hd:3, ha:6, hp:1, vt:7, vs:1, vd:2, va:4, vp:1};
    // gb: active-low, window covering the whole line and frame.
    gb = '{ht:9, hs:3, hd:0, ha:9, hp:0, vt:5, vs:2, vd:0, va:5, vp:0};
    // gc: zero-width line sync, mixed polarity, windows overrun the totals.
    gc = '{ht:10, hs:0, hd:7, ha:8, hp:1, vt:4, vs:3, vd:1, va:10, vp:0};

    rst_n = 1'b0;
    apply(gb);
    repeat (4) @(negedge clk);
    // R1: active-low polarity on the inputs must not reach the outputs in reset.
    chk("R1", "hsync_o in reset", int'(hsync_o), 0);
    chk("R1", "vsync_o in reset", int'(vsync_o), 0);
    chk("R1", "de_o in reset",    int'(de_o),    0);
    chk("R1", "sof_o in reset",   int'(sof_o),   0);
    chk("R1", "col_o in reset",   int'(col_o),   0);
    chk("R1", "row_o in reset",   int'(row_o),   0);
    apply(ga);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: after the first edge the outputs are still all zero.
    chk("R1", "sof_o edge1",   int'(sof_o),   0);
    chk("R1", "hsync_o edge1", int'(hsync_o), 0);
    chk("R1", "de_o edge1",    int'(de_o),    0);
    @(negedge clk);
    // R1: start of frame after the second edge.
    chk("R1", "sof_o edge2", int'(sof_o), 1);

    // R2: switch to gb mid-frame; this frame must keep ga.
    run_frame(ga, 30, gb, " R2 held");
    run_frame(gb, -1, gb, " R2 applied");
    run_frame(gb, 5, gc, " R2 held");
    run_frame(gc, -1, gc, " R2 applied");
    run_frame(gc, 17, ga, " R2 held");
    run_frame(ga, -1, ga, " R2 applied");

    done = 1;
    report();
    $finish;
  end

endmodule